// File: doc/BRIEF.md
# Dual-Bus Memory Block Conflict Arbiter

This block is the front end of a banked on-chip memory. A processor core can issue two accesses in each cycle. One comes on a data bus that only moves data. The other comes on a program bus that may carry either an instruction fetch or a second data word. The address space is split into equal blocks, and the fixed top address bits select the block. Each block is a dual-ported RAM. The two core buses share one port of each block, and a separate I/O bus owns the other port.

When the two core buses address different blocks, both accesses complete in the same cycle. When they address the same block, the data-bus access is performed at once. The program-bus access is captured into a holding register and performed in the following cycle. During that following cycle the core is told to stall, and its bus inputs are not acted on. I/O accesses run on their own port, so they never cause a stall.

Read data for each bus returns from a register one cycle after the grant, with a valid flag for each bus.

Top module: `dualbus_mem`

## Requirements
- R1: When the data and program buses both request and their block indices differ, both `dm_gnt` and `pm_gnt` are high in that cycle, and `stall` stays low in the next cycle.
- R2: When both core buses request the same block while `stall` is low, `dm_gnt` is high and `pm_gnt` is low in that cycle. In the next cycle `stall` and `pm_gnt` are both high.
- R3: `stall` is high only in the single cycle that follows a same-block collision, and never in two consecutive cycles.
- R4: In a `stall` cycle, the data and program bus inputs are ignored: `dm_gnt` is low, and no write from either core bus reaches memory.
- R5: The program access performed in the stall cycle uses the address, write enable and write data captured in the collision cycle, even if the program bus inputs change.
- R6: A granted read (write enable low) raises that bus's `rvalid` one cycle later. The `rdata` then holds the word as it was before any write in the grant cycle.
- R7: An I/O access is served in the cycle it is requested, whatever the core buses do. An I/O read raises `io_rvalid` one cycle later, and I/O traffic never raises `stall`.
- R8: If a core write and an I/O access hit the same word in the same cycle, the word ends up holding the core data. An I/O read in that cycle returns the old contents.
- R9: The block index is the top log2(NUM_BLK) address bits, and the word offset is the remaining low bits. With the defaults the address is 12 bits: bits 11:10 select one of 4 blocks and bits 9:0 select one of 1024 words.
- R10: A synchronous active-high `rst` clears the pending collision and all `rvalid` flags. In the cycle after reset, `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dm_req | input | 1 | Data bus access request |
| dm_we | input | 1 | Data bus write enable |
| dm_addr | input | ADDR_W | Data bus word address |
| dm_wdata | input | DATA_W | Data bus write data |
| pm_req | input | 1 | Program bus access request |
| pm_we | input | 1 | Program bus write enable |
| pm_addr | input | ADDR_W | Program bus word address |
| pm_wdata | input | DATA_W | Program bus write data |
| io_req | input | 1 | I/O bus access request |
| io_we | input | 1 | I/O bus write enable |
| io_addr | input | ADDR_W | I/O bus word address |
| io_wdata | input | DATA_W | I/O bus write data |
| dm_gnt | output | 1 | Data bus access performed this cycle |
| pm_gnt | output | 1 | Program bus (live or held) access performed this cycle |
| stall | output | 1 | Core must hold; held program access executes |
| dm_rvalid | output | 1 | Data bus read data valid |
| dm_rdata | output | DATA_W | Data bus read data |
| pm_rvalid | output | 1 | Program bus read data valid |
| pm_rdata | output | DATA_W | Program bus read data |
| io_rvalid | output | 1 | I/O read data valid |
| io_rdata | output | DATA_W | I/O read data |

## Verification
Two kinds of event can fall in the same cycle. The first is a core write and an I/O access to the same word. The second is the held program access in a stall cycle and fresh core bus activity that must be ignored. The bench provokes both. Directed steps put a core write and an I/O read on one word in one cycle, and they change the program address and start a data write during a stall. A long random phase then draws every address from a small set of words, so collisions and same-word overlaps occur often. A behavioural model with its own memory array and pending flag predicts grants, stall and every read word. Each read word is judged against the order in which the model applied old-data reads, then the I/O write, then the core write.

// File: rtl/dualbus_pkg.sv
package dualbus_pkg;

   // which core bus drives a block's shared core port in a cycle
   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_DM   = 2'd1,
      SRC_PM   = 2'd2
   } core_src_e;

endpackage

// File: rtl/dualbus_arb.sv
module dualbus_arb #(
   parameter int DATA_W = 32,
   parameter int BLK_W  = 2,
   parameter int OFF_W  = 10,
   localparam int ADDR_W = BLK_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dm_req,
   input  logic              dm_we,
   input  logic [ADDR_W-1:0] dm_addr,
   input  logic              pm_req,
   input  logic              pm_we,
   input  logic [ADDR_W-1:0] pm_addr,
   input  logic [DATA_W-1:0] pm_wdata,
   output logic              dm_go,
   output logic              pm_go,
   output logic              held_now,
   output logic              pm_x_we,
   output logic [ADDR_W-1:0] pm_x_addr,
   output logic [DATA_W-1:0] pm_x_wdata,
   output logic              dm_rd_go,
   output logic              pm_rd_go
);

   logic              pend_q;
   logic              hold_we_q;
   logic [ADDR_W-1:0] hold_addr_q;
   logic [DATA_W-1:0] hold_wdata_q;
   logic              clash;

   // same block on both core buses, evaluated only outside a stall cycle
   always_comb begin
      clash = dm_req && pm_req && !pend_q &&
              (dm_addr[ADDR_W-1 -: BLK_W] == pm_addr[ADDR_W-1 -: BLK_W]);
   end

   always_comb begin
      dm_go      = dm_req && !pend_q;
      pm_go      = pend_q || (pm_req && !clash);
      held_now   = pend_q;
      pm_x_we    = pend_q ? hold_we_q    : pm_we;
      pm_x_addr  = pend_q ? hold_addr_q  : pm_addr;
      pm_x_wdata = pend_q ? hold_wdata_q : pm_wdata;
      dm_rd_go   = dm_go && !dm_we;
      pm_rd_go   = pm_go && !pm_x_we;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= 1'b0;
      end else begin
         pend_q <= clash;
      end
   end

   always_ff @(posedge clk) begin
      if (clash) begin
         hold_we_q    <= pm_we;
         hold_addr_q  <= pm_addr;
         hold_wdata_q <= pm_wdata;
      end
   end

endmodule

// File: rtl/dualbus_bank.sv
module dualbus_bank #(
   parameter int DATA_W = 32,
   parameter int OFF_W  = 10,
   localparam int DEPTH = 1 << OFF_W
) (
   input  logic              clk,
   input  logic              c_en,
   input  logic              c_we,
   input  logic [OFF_W-1:0]  c_off,
   input  logic [DATA_W-1:0] c_wdata,
   output logic [DATA_W-1:0] c_rdata,
   input  logic              x_en,
   input  logic              x_we,
   input  logic [OFF_W-1:0]  x_off,
   input  logic [DATA_W-1:0] x_wdata,
   output logic [DATA_W-1:0] x_rdata
);

   logic [DATA_W-1:0] cells [DEPTH];

   // Reads see the old word. The core port write is applied last, so it
   // wins over an I/O write to the same word.
   always_ff @(posedge clk) begin
      if (x_en) begin
         x_rdata <= cells[x_off];
         if (x_we) cells[x_off] <= x_wdata;
      end
      if (c_en) begin
         c_rdata <= cells[c_off];
         if (c_we) cells[c_off] <= c_wdata;
      end
   end

endmodule

// File: rtl/dualbus_ret.sv
module dualbus_ret #(
   parameter int DATA_W  = 32,
   parameter int NUM_BLK = 4,
   localparam int BLK_W  = $clog2(NUM_BLK)
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            dm_rd_go,
   input  logic [BLK_W-1:0]                dm_blk,
   input  logic                            pm_rd_go,
   input  logic [BLK_W-1:0]                pm_blk,
   input  logic                            io_rd_go,
   input  logic [BLK_W-1:0]                io_blk,
   input  logic [NUM_BLK-1:0][DATA_W-1:0]  core_q,
   input  logic [NUM_BLK-1:0][DATA_W-1:0]  io_q,
   output logic                            dm_rvalid,
   output logic [DATA_W-1:0]               dm_rdata,
   output logic                            pm_rvalid,
   output logic [DATA_W-1:0]               pm_rdata,
   output logic                            io_rvalid,
   output logic [DATA_W-1:0]               io_rdata
);

   logic [BLK_W-1:0] dm_sel_q, pm_sel_q, io_sel_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         dm_rvalid <= 1'b0;
         pm_rvalid <= 1'b0;
         io_rvalid <= 1'b0;
      end else begin
         dm_rvalid <= dm_rd_go;
         pm_rvalid <= pm_rd_go;
         io_rvalid <= io_rd_go;
      end
   end

   always_ff @(posedge clk) begin
      if (dm_rd_go) dm_sel_q <= dm_blk;
      if (pm_rd_go) pm_sel_q <= pm_blk;
      if (io_rd_go) io_sel_q <= io_blk;
   end

   always_comb begin
      dm_rdata = core_q[dm_sel_q];
      pm_rdata = core_q[pm_sel_q];
      io_rdata = io_q[io_sel_q];
   end

endmodule

// File: rtl/dualbus_mem.sv
module dualbus_mem #(
   parameter int DATA_W    = 32,
   parameter int NUM_BLK   = 4,
   parameter int BLK_DEPTH = 1024,
   localparam int BLK_W    = $clog2(NUM_BLK),
   localparam int OFF_W    = $clog2(BLK_DEPTH),
   localparam int ADDR_W   = BLK_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dm_req,
   input  logic              dm_we,
   input  logic [ADDR_W-1:0] dm_addr,
   input  logic [DATA_W-1:0] dm_wdata,
   input  logic              pm_req,
   input  logic              pm_we,
   input  logic [ADDR_W-1:0] pm_addr,
   input  logic [DATA_W-1:0] pm_wdata,
   input  logic              io_req,
   input  logic              io_we,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic              dm_gnt,
   output logic              pm_gnt,
   output logic              stall,
   output logic              dm_rvalid,
   output logic [DATA_W-1:0] dm_rdata,
   output logic              pm_rvalid,
   output logic [DATA_W-1:0] pm_rdata,
   output logic              io_rvalid,
   output logic [DATA_W-1:0] io_rdata
);
   import dualbus_pkg::*;

   // elaboration-time parameter checks
   if (NUM_BLK < 2 || (1 << BLK_W) != NUM_BLK) begin : g_bad_blocks
      $error("NUM_BLK must be a power of two of at least 2");
   end
   if (BLK_DEPTH < 2 || (1 << OFF_W) != BLK_DEPTH) begin : g_bad_depth
      $error("BLK_DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be positive");
   end

   logic              dm_go, pm_go, held_now;
   logic              pm_x_we;
   logic [ADDR_W-1:0] pm_x_addr;
   logic [DATA_W-1:0] pm_x_wdata;
   logic              dm_rd_go, pm_rd_go;

   logic [BLK_W-1:0]  dm_blk, pm_blk, io_blk;
   logic [OFF_W-1:0]  dm_off, pm_off, io_off;

   logic [NUM_BLK-1:0][DATA_W-1:0] core_q;
   logic [NUM_BLK-1:0][DATA_W-1:0] io_q;

   dualbus_arb #(.DATA_W(DATA_W), .BLK_W(BLK_W), .OFF_W(OFF_W)) u_arb (
      .clk        (clk),
      .rst        (rst),
      .dm_req     (dm_req),
      .dm_we      (dm_we),
      .dm_addr    (dm_addr),
      .pm_req     (pm_req),
      .pm_we      (pm_we),
      .pm_addr    (pm_addr),
      .pm_wdata   (pm_wdata),
      .dm_go      (dm_go),
      .pm_go      (pm_go),
      .held_now   (held_now),
      .pm_x_we    (pm_x_we),
      .pm_x_addr  (pm_x_addr),
      .pm_x_wdata (pm_x_wdata),
      .dm_rd_go   (dm_rd_go),
      .pm_rd_go   (pm_rd_go)
   );

   always_comb begin
      dm_blk = dm_addr[ADDR_W-1 -: BLK_W];
      dm_off = dm_addr[OFF_W-1:0];
      pm_blk = pm_x_addr[ADDR_W-1 -: BLK_W];
      pm_off = pm_x_addr[OFF_W-1:0];
      io_blk = io_addr[ADDR_W-1 -: BLK_W];
      io_off = io_addr[OFF_W-1:0];
      dm_gnt = dm_go;
      pm_gnt = pm_go;
      stall  = held_now;
   end

   for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
      core_src_e         src;
      logic              c_en, c_we, x_en;
      logic [OFF_W-1:0]  c_off;
      logic [DATA_W-1:0] c_wdata;

      always_comb begin
         src = SRC_NONE;
         if (dm_go && dm_blk == BLK_W'(k))      src = SRC_DM;
         else if (pm_go && pm_blk == BLK_W'(k)) src = SRC_PM;
         c_en    = (src != SRC_NONE);
         c_we    = (src == SRC_DM) ? dm_we    : (src == SRC_PM) ? pm_x_we    : 1'b0;
         c_off   = (src == SRC_DM) ? dm_off   : pm_off;
         c_wdata = (src == SRC_DM) ? dm_wdata : pm_x_wdata;
         x_en    = io_req && (io_blk == BLK_W'(k));
      end

      dualbus_bank #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_bank (
         .clk     (clk),
         .c_en    (c_en),
         .c_we    (c_we),
         .c_off   (c_off),
         .c_wdata (c_wdata),
         .c_rdata (core_q[k]),
         .x_en    (x_en),
         .x_we    (io_we),
         .x_off   (io_off),
         .x_wdata (io_wdata),
         .x_rdata (io_q[k])
      );
   end

   dualbus_ret #(.DATA_W(DATA_W), .NUM_BLK(NUM_BLK)) u_ret (
      .clk       (clk),
      .rst       (rst),
      .dm_rd_go  (dm_rd_go),
      .dm_blk    (dm_blk),
      .pm_rd_go  (pm_rd_go),
      .pm_blk    (pm_blk),
      .io_rd_go  (io_req && !io_we),
      .io_blk    (io_blk),
      .core_q    (core_q),
      .io_q      (io_q),
      .dm_rvalid (dm_rvalid),
      .dm_rdata  (dm_rdata),
      .pm_rvalid (pm_rvalid),
      .pm_rdata  (pm_rdata),
      .io_rvalid (io_rvalid),
      .io_rdata  (io_rdata)
   );

endmodule

// File: rtl/dualbus_mem_chk.sv
module dualbus_mem_chk #(
   parameter int ADDR_W = 12,
   parameter int BLK_W  = 2
) (
   input logic              clk,
   input logic              rst,
   input logic              dm_req,
   input logic              dm_we,
   input logic [ADDR_W-1:0] dm_addr,
   input logic              pm_req,
   input logic [ADDR_W-1:0] pm_addr,
   input logic              io_req,
   input logic              io_we,
   input logic              dm_gnt,
   input logic              pm_gnt,
   input logic              stall,
   input logic              dm_rvalid,
   input logic              io_rvalid
);

   logic same_blk;
   assign same_blk = dm_addr[ADDR_W-1 -: BLK_W] == pm_addr[ADDR_W-1 -: BLK_W];

   AST_SPLIT_BOTH: assert property (@(posedge clk) disable iff (rst)
      (dm_req && pm_req && !stall && !same_blk) |-> (dm_gnt && pm_gnt)) else $error("split"); // R1
   AST_SPLIT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
      (dm_req && pm_req && !stall && !same_blk) |=> !stall) else $error("split stall"); // R1
   AST_DM_FIRST: assert property (@(posedge clk) disable iff (rst)
      (dm_req && pm_req && !stall && same_blk) |-> (dm_gnt && !pm_gnt)) else $error("order"); // R2
   AST_PM_NEXT: assert property (@(posedge clk) disable iff (rst)
      (dm_req && pm_req && !stall && same_blk) |=> (stall && pm_gnt)) else $error("held"); // R2
   AST_STALL_SINGLE: assert property (@(posedge clk) disable iff (rst)
      stall |=> !stall) else $error("stall twice"); // R3
   AST_STALL_CAUSED: assert property (@(posedge clk) disable iff (rst)
      (!stall && !(dm_req && pm_req)) |=> !stall) else $error("spurious stall"); // R3
   AST_STALL_MUTES_DM: assert property (@(posedge clk) disable iff (rst)
      stall |-> !dm_gnt) else $error("dm during stall"); // R4
   AST_DM_READ_LAT: assert property (@(posedge clk) disable iff (rst)
      (dm_gnt && !dm_we) |=> dm_rvalid) else $error("dm latency"); // R6
   AST_IO_READ_LAT: assert property (@(posedge clk) disable iff (rst)
      (io_req && !io_we) |=> io_rvalid) else $error("io latency"); // R7
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (!stall && !dm_rvalid && !io_rvalid)) else $error("reset"); // R10

endmodule

bind dualbus_mem dualbus_mem_chk #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .dm_req    (dm_req),
   .dm_we     (dm_we),
   .dm_addr   (dm_addr),
   .pm_req    (pm_req),
   .pm_addr   (pm_addr),
   .io_req    (io_req),
   .io_we     (io_we),
   .dm_gnt    (dm_gnt),
   .pm_gnt    (pm_gnt),
   .stall     (stall),
   .dm_rvalid (dm_rvalid),
   .io_rvalid (io_rvalid)
);

// File: tb/sim_dualbus_mem.sv
`timescale 1ns/1ps
module sim_dualbus_mem;
   localparam int DW = 32;
   localparam int AW = 12;   // R9: bits 11:10 block, bits 9:0 word
   localparam int WORDS = 4096;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic d_req = 0, d_we = 0, p_req = 0, p_we = 0, i_req = 0, i_we = 0;
   logic [AW-1:0] d_addr = '0, p_addr = '0, i_addr = '0;
   logic [DW-1:0] d_wd = '0, p_wd = '0, i_wd = '0;

   logic dm_gnt, pm_gnt, stall, dm_rvalid, pm_rvalid, io_rvalid;
   logic [DW-1:0] dm_rdata, pm_rdata, io_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   // behavioural reference state
   logic [DW-1:0] m [WORDS];
   bit            pend = 0;
   bit            h_we;
   logic [AW-1:0] h_a;
   logic [DW-1:0] h_d;
   bit            e_dv = 0, e_pv = 0, e_iv = 0;
   logic [DW-1:0] e_dd, e_pd, e_id;

   always #10 clk = ~clk;   // 50 MHz

   dualbus_mem u0 (
      .clk(clk), .rst(rst),
      .dm_req(d_req), .dm_we(d_we), .dm_addr(d_addr), .dm_wdata(d_wd),
      .pm_req(p_req), .pm_we(p_we), .pm_addr(p_addr), .pm_wdata(p_wd),
      .io_req(i_req), .io_we(i_we), .io_addr(i_addr), .io_wdata(i_wd),
      .dm_gnt(dm_gnt), .pm_gnt(pm_gnt), .stall(stall),
      .dm_rvalid(dm_rvalid), .dm_rdata(dm_rdata),
      .pm_rvalid(pm_rvalid), .pm_rdata(pm_rdata),
      .io_rvalid(io_rvalid), .io_rdata(io_rdata)
   );

   task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   function automatic logic [AW-1:0] mk(input int blk, input int off);
      return AW'((blk << 10) | off);
   endfunction

   function automatic logic [AW-1:0] rnd_addr();
      return mk(int'($urandom_range(3)), int'($urandom_range(7)));
   endfunction

   // compare outputs against the model, then advance the model at the edge
   task automatic step();
      bit conf, dgo, pgo, pw;
      logic [AW-1:0] pa;
      logic [DW-1:0] pd;
      #5;
      conf = d_req && p_req && !pend && (d_addr[11:10] == p_addr[11:10]);
      dgo  = d_req && !pend;
      pgo  = pend || (p_req && !conf);
      if (rst) begin
         chk("R10 stall", {31'b0, stall}, {31'b0, pend});
      end else begin
         chk("R3 stall", {31'b0, stall}, {31'b0, pend});
         chk("R4 dm_gnt", {31'b0, dm_gnt}, {31'b0, dgo});
         chk("R1 R2 pm_gnt", {31'b0, pm_gnt}, {31'b0, pgo});
      end
      chk("R10 R6 dm_rvalid", {31'b0, dm_rvalid}, {31'b0, e_dv});
      chk("R10 R5 pm_rvalid", {31'b0, pm_rvalid}, {31'b0, e_pv});
      chk("R10 R7 io_rvalid", {31'b0, io_rvalid}, {31'b0, e_iv});
      if (e_dv) chk("R6 R9 dm_rdata", dm_rdata, e_dd);
      if (e_pv) chk("R5 R9 pm_rdata", pm_rdata, e_pd);
      if (e_iv) chk("R7 R8 io_rdata", io_rdata, e_id);
      @(posedge clk);
      pa = pend ? h_a : p_addr;
      pw = pend ? h_we : p_we;
      pd = pend ? h_d : p_wd;
      e_dv = dgo && !d_we;
      if (e_dv) e_dd = m[d_addr];
      e_pv = pgo && !pw;
      if (e_pv) e_pd = m[pa];
      e_iv = i_req && !i_we;
      if (e_iv) e_id = m[i_addr];
      if (i_req && i_we) m[i_addr] = i_wd;
      if (dgo && d_we) m[d_addr] = d_wd;   // R8: core write applied last
      if (pgo && pw) m[pa] = pd;
      if (conf) begin
         h_a = p_addr; h_we = p_we; h_d = p_wd;
      end
      pend = conf;
      if (rst) begin
         pend = 0; e_dv = 0; e_pv = 0; e_iv = 0;
      end
      @(negedge clk);
   endtask

   task automatic idle();
      d_req = 0; p_req = 0; i_req = 0; d_we = 0; p_we = 0; i_we = 0;
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      // R10: reset state
      for (int i = 0; i < 3; i++) step();
      rst = 0;
      // preload 8 words of every block through the I/O port (R9 mapping)
      for (int b = 0; b < 4; b++)
         for (int o = 0; o < 8; o++) begin
            idle(); i_req = 1; i_we = 1; i_addr = mk(b, o); i_wd = $urandom();
            step();
         end
      // R1: different blocks, both reads in one cycle
      idle(); d_req = 1; d_addr = mk(0, 1); p_req = 1; p_addr = mk(1, 2); step();
      idle(); step();
      // R2 R5: same-block collision, then program bus changes during stall
      idle(); d_req = 1; d_addr = mk(2, 3); p_req = 1; p_addr = mk(2, 4); step();
      // R4: dm write and new pm request during stall must be ignored
      d_we = 1; d_wd = 32'hDEAD_BEEF; d_addr = mk(2, 4); p_addr = mk(3, 5); p_we = 1; p_wd = 32'h1111_2222; step();
      idle(); d_req = 1; d_addr = mk(2, 4); step();
      idle(); p_req = 1; p_addr = mk(3, 5); step();
      // collision with writes on both buses
      idle(); d_req = 1; d_we = 1; d_addr = mk(1, 0); d_wd = 32'hA5A5_0001;
      p_req = 1; p_we = 1; p_addr = mk(1, 6); p_wd = 32'h5A5A_0002; step();
      idle(); step();
      idle(); d_req = 1; d_addr = mk(1, 6); p_req = 1; p_addr = mk(0, 0); step();
      // R8: core write with I/O read of the same word, then I/O write vs pm write
      idle(); d_req = 1; d_we = 1; d_addr = mk(3, 7); d_wd = 32'h0BAD_F00D;
      i_req = 1; i_addr = mk(3, 7); step();
      idle(); p_req = 1; p_we = 1; p_addr = mk(0, 7); p_wd = 32'h0C0C_0C0C;
      i_req = 1; i_we = 1; i_addr = mk(0, 7); i_wd = 32'h0D0D_0D0D; step();
      idle(); i_req = 1; i_addr = mk(0, 7); step();
      // R10: reset arriving in the stall cycle
      idle(); d_req = 1; d_addr = mk(1, 1); p_req = 1; p_addr = mk(1, 2); step();
      idle(); rst = 1; step();
      rst = 0; step();
      step();
      // random traffic over a small address set
      for (int n = 0; n < 4000; n++) begin
         d_req = 1'($urandom_range(1)); d_we = 1'($urandom_range(1));
         d_addr = rnd_addr(); d_wd = $urandom();
         p_req = 1'($urandom_range(1)); p_we = 1'($urandom_range(1));
         p_addr = rnd_addr(); p_wd = $urandom();
         i_req = 1'($urandom_range(1)); i_we = 1'($urandom_range(1));
         i_addr = rnd_addr(); i_wd = $urandom();
         step();
      end
      idle(); step(); step();
      summary();
      $finish;
   end
endmodule